// File: doc/BRIEF.md
# DMA External Handshake Controller

This block is the control sequencer for a single DMA channel. An outside master starts the channel, or wakes it from a pause, with an edge on a request line. The block acknowledges while work is in flight and emits a one-cycle completion pulse when the channel is free for a new command. Software controls reach the block as plain level or pulse inputs. Status comes back as plain outputs: the channel-start bit, a busy flag and a sticky error flag.

Data movement is reduced to a stream of 8-byte beats on a valid/ready pair. The mover takes a beat on any cycle where both are high. `beat_valid` stays high while `beat_ready` is low and never drops without an accepted beat, except when a pause or a failure intervenes. Descriptor reads in chaining modes are a request held until a completion pulse, which returns the segment's beat count and a last-segment flag. An optional quota pause stops the channel after a programmed number of bytes. Only the external request edge restarts it.

Top module: `dma_xhs_ctrl`

## Requirements
- R1: After reset, `ext_ack`, `busy_stat`, `start_bit`, `ext_done`, `err_stat`, `beat_valid` and `fetch_req` are all low.
- R2: While idle, a 0-to-1 transition of `ext_req` with `ext_ctl_en` high, or a `sw_start` pulse, starts the channel. On the following cycle `busy_stat`, `ext_ack` and `start_bit` are high. With `ext_ctl_en` low, an `ext_req` edge is ignored. Holding `ext_req` high or lowering it never clears `start_bit`.
- R3: In direct modes the channel completes after exactly `xfer_beats` accepted beats (`beat_valid && beat_ready`), including zero, under any back-pressure pattern.
- R4: `ext_done` is a single-cycle pulse. In that cycle `busy_stat`, `ext_ack` and `start_bit` are already low.
- R5: With `pause_en` high, once the bytes accepted since the last start or resume reach 2^`quota_exp` (8 bytes per beat) and beats remain, `start_bit` clears and `beat_valid` drops while `busy_stat` stays high. A transfer whose final beat reaches the quota completes without pausing.
- R6: A paused channel resumes only on an enabled `ext_req` rising edge. The resume sets `start_bit` and restarts the byte count. Only the quota logic can clear `start_bit` on a busy channel.
- R7: Chaining is selected by `xfer_mode` bit 0 = 1. A `desc_load` pulse (or any start) then issues `fetch_req`, held until `fetch_done`. Segments of `fetch_beats` beats follow until one flagged `fetch_last` is finished. `desc_load` is ignored in direct modes.
- R8: With `xfer_mode` bit 1 = 1 (extended) and chaining, each descriptor takes two fetch handshakes. The beat count and last flag of the second handshake are used.
- R9: No pause occurs during descriptor fetch: `fetch_req` high implies `start_bit` high.
- R10: A 0-to-1 transition of `abort_req` while busy ends the transfer on the next cycle with an `ext_done` pulse and `err_stat` set.
- R11: A `xfer_err` pulse while busy ends the transfer in the same way as R10.
- R12: `err_stat` is sticky. A pulse on `err_clr` clears it. A new failure in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_ctl_en | input | 1 | Enables external request control |
| pause_en | input | 1 | Enables the byte-quota pause |
| xfer_mode | input | 2 | bit 0 chaining, bit 1 extended |
| quota_exp | input | QEXP_W | Quota exponent: 2^n bytes |
| xfer_beats | input | LEN_W | Beat count for direct modes |
| sw_start | input | 1 | Software start pulse |
| desc_load | input | 1 | Descriptor-address write pulse (chaining start) |
| abort_req | input | 1 | Abort control bit (edge-acting) |
| err_clr | input | 1 | Write-one-to-clear for `err_stat` |
| xfer_err | input | 1 | Transfer error pulse |
| ext_req | input | 1 | External start/resume request |
| ext_ack | output | 1 | Transfer in progress |
| ext_done | output | 1 | Completion pulse |
| start_bit | output | 1 | Channel-start bit |
| busy_stat | output | 1 | Busy status |
| err_stat | output | 1 | Sticky error status |
| beat_valid | output | 1 | Beat offered to the mover |
| beat_ready | input | 1 | Mover accepts the beat |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_done | input | 1 | Descriptor fetch completion pulse |
| fetch_beats | input | LEN_W | Beats in the fetched segment |
| fetch_last | input | 1 | Fetched segment is the last one |

## Verification
The bench uses the defaults: LEN_W = 16, QEXP_W = 4, BEAT_BYTES = 8. At run time it selects quota exponents of 3 and 4, so the channel pauses after every one or two beats. Short transfers therefore reach several pauses, a quota that lands exactly on the final beat, and a pause that is held over a descriptor fetch. The chaining runs use one- and two-beat segments, so each segment boundary and both fetch phases of the extended mode occur within a few cycles.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2
  } dhc_state_e;

  localparam int MODE_CHAIN_BIT = 0;
  localparam int MODE_EXT_BIT   = 1;
endpackage

// File: rtl/dhc_edge.sv
module dhc_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/dhc_quota.sv
module dhc_quota #(
  parameter int QEXP_W     = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat_acc,
  input  logic              pause_en,
  input  logic [QEXP_W-1:0] quota_exp,
  output logic              hit
);
  localparam int CNT_W = (1 << QEXP_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] quota;

  assign quota = {{(CNT_W-1){1'b0}}, 1'b1} << quota_exp;

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (clear)                       cnt_q <= '0;
    else if (beat_acc && !cnt_q[CNT_W-1]) cnt_q <= cnt_q + CNT_W'(BEAT_BYTES);
  end

  assign hit = pause_en && (cnt_q >= quota);

  // The count restarts on a start or resume, so the quota is met afresh.
  assert_clear_drops_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hit);
endmodule

// File: rtl/dhc_seq.sv
module dhc_seq
  import dhc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       xfer_mode,
  input  logic [LEN_W-1:0] xfer_beats,
  input  logic             go_ext,
  input  logic             sw_start,
  input  logic             desc_load,
  input  logic             abort_rise,
  input  logic             xfer_err,
  input  logic             err_clr,
  input  logic             quota_hit,
  input  logic             beat_ready,
  input  logic             fetch_done,
  input  logic [LEN_W-1:0] fetch_beats,
  input  logic             fetch_last,
  output logic             busy,
  output logic             cs,
  output logic             done,
  output logic             err_flag,
  output logic             beat_valid,
  output logic             fetch_req,
  output logic             beat_acc,
  output logic             quota_clr
);
  dhc_state_e       state_q;
  logic [LEN_W-1:0] rem_q;
  logic             last_q, phase_q, cs_q, done_q, err_q;
  logic             chain, extd, launch, resume, fail;

  assign chain  = xfer_mode[MODE_CHAIN_BIT];
  assign extd   = xfer_mode[MODE_EXT_BIT];
  assign busy   = (state_q != ST_IDLE);
  assign launch = (state_q == ST_IDLE) && (go_ext || sw_start || (desc_load && chain));
  assign resume = (state_q == ST_MOVE) && !cs_q && go_ext;
  assign fail   = busy && (abort_rise || xfer_err);

  assign beat_valid = (state_q == ST_MOVE) && cs_q && (rem_q != '0) && !quota_hit;
  assign beat_acc   = beat_valid && beat_ready;
  assign quota_clr  = launch || resume;
  assign fetch_req  = (state_q == ST_FETCH);
  assign cs         = cs_q;
  assign done       = done_q;
  assign err_flag   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      last_q  <= 1'b0;
      phase_q <= 1'b0;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fail)         err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;

      if (fail) begin
        state_q <= ST_IDLE;
        cs_q    <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (launch) begin
              cs_q    <= 1'b1;
              phase_q <= 1'b0;
              if (chain) begin
                state_q <= ST_FETCH;
              end else begin
                state_q <= ST_MOVE;
                rem_q   <= xfer_beats;
                last_q  <= 1'b1;
              end
            end
          end
          ST_FETCH: begin
            if (fetch_done) begin
              if (extd && !phase_q) begin
                phase_q <= 1'b1;
              end else begin
                phase_q <= 1'b0;
                rem_q   <= fetch_beats;
                last_q  <= fetch_last;
                state_q <= ST_MOVE;
              end
            end
          end
          ST_MOVE: begin
            if (rem_q == '0) begin
              if (last_q) begin
                state_q <= ST_IDLE;
                cs_q    <= 1'b0;
                done_q  <= 1'b1;
              end else begin
                state_q <= ST_FETCH;
              end
            end else if (!cs_q) begin
              if (go_ext) cs_q <= 1'b1;
            end else if (quota_hit) begin
              cs_q <= 1'b0;
            end else if (beat_ready) begin
              rem_q <= rem_q - LEN_W'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cs));
  assert_valid_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (cs && busy));
  assert_fetch_keeps_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> cs);
  assert_pause_only_quota_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $fell(cs)) |-> $past(quota_hit));
  assert_resume_sets_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs && go_ext && !fail) |=> cs);
  assert_abort_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_rise) |=> (done && err_flag));
  assert_err_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_err) |=> (done && !busy));
  assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && err_clr && !fail) |=> !err_flag);
endmodule

// File: rtl/dma_xhs_ctrl.sv
module dma_xhs_ctrl #(
  parameter int LEN_W      = 16,
  parameter int QEXP_W     = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_ctl_en,
  input  logic              pause_en,
  input  logic [1:0]        xfer_mode,
  input  logic [QEXP_W-1:0] quota_exp,
  input  logic [LEN_W-1:0]  xfer_beats,
  input  logic              sw_start,
  input  logic              desc_load,
  input  logic              abort_req,
  input  logic              err_clr,
  input  logic              xfer_err,
  input  logic              ext_req,
  output logic              ext_ack,
  output logic              ext_done,
  output logic              start_bit,
  output logic              busy_stat,
  output logic              err_stat,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic              fetch_req,
  input  logic              fetch_done,
  input  logic [LEN_W-1:0]  fetch_beats,
  input  logic              fetch_last
);
  logic [1:0] rise;
  logic       go_ext, quota_hit, quota_clr, beat_acc, busy;

  dhc_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({abort_req, ext_req}),
    .rise (rise)
  );

  assign go_ext = rise[0] && ext_ctl_en;

  dhc_quota #(.QEXP_W(QEXP_W), .BEAT_BYTES(BEAT_BYTES)) u_quota (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (quota_clr),
    .beat_acc (beat_acc),
    .pause_en (pause_en),
    .quota_exp(quota_exp),
    .hit      (quota_hit)
  );

  dhc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_mode  (xfer_mode),
    .xfer_beats (xfer_beats),
    .go_ext     (go_ext),
    .sw_start   (sw_start),
    .desc_load  (desc_load),
    .abort_rise (rise[1]),
    .xfer_err   (xfer_err),
    .err_clr    (err_clr),
    .quota_hit  (quota_hit),
    .beat_ready (beat_ready),
    .fetch_done (fetch_done),
    .fetch_beats(fetch_beats),
    .fetch_last (fetch_last),
    .busy       (busy),
    .cs         (start_bit),
    .done       (ext_done),
    .err_flag   (err_stat),
    .beat_valid (beat_valid),
    .fetch_req  (fetch_req),
    .beat_acc   (beat_acc),
    .quota_clr  (quota_clr)
  );

  assign ext_ack   = busy;
  assign busy_stat = busy;
endmodule

// File: tb/dma_xhs_ctrl_tb_top.sv
module dma_xhs_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_ctl_en = 1'b0, pause_en = 1'b0;
  logic [1:0]  xfer_mode = 2'd0;
  logic [3:0]  quota_exp = 4'd0;
  logic [15:0] xfer_beats = 16'd0;
  logic        sw_start = 1'b0, desc_load = 1'b0, abort_req = 1'b0;
  logic        err_clr = 1'b0, xfer_err = 1'b0, ext_req = 1'b0;
  logic        ext_ack, ext_done, start_bit, busy_stat, err_stat;
  logic        beat_valid, beat_ready = 1'b1, fetch_req;
  logic        fetch_done = 1'b0, fetch_last = 1'b0;
  logic [15:0] fetch_beats = 16'd0;

  dma_xhs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_ctl_en(ext_ctl_en), .pause_en(pause_en),
    .xfer_mode(xfer_mode), .quota_exp(quota_exp), .xfer_beats(xfer_beats),
    .sw_start(sw_start), .desc_load(desc_load), .abort_req(abort_req),
    .err_clr(err_clr), .xfer_err(xfer_err), .ext_req(ext_req),
    .ext_ack(ext_ack), .ext_done(ext_done), .start_bit(start_bit),
    .busy_stat(busy_stat), .err_stat(err_stat), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .fetch_req(fetch_req), .fetch_done(fetch_done),
    .fetch_beats(fetch_beats), .fetch_last(fetch_last)
  );

  always #2 clk = ~clk;

  typedef struct packed { int beats; bit err; } exp_t;
  exp_t sbq[$];
  int checks = 0, fails = 0, mon_beats = 0;
  int seg_b[4];
  int seg_n = 0;
  bit ext_mode = 0, bp = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: counts accepted beats, pops the scoreboard on each completion.
  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_valid && beat_ready) mon_beats++;
      if (ext_done) begin
        if (sbq.size() == 0) begin
          chk("R4 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.beats >= 0) chk("R3 beats at done", mon_beats, e.beats);
          chk("R10/R11 err at done", int'(err_stat), int'(e.err));
        end
        mon_beats = 0;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_ext();
    tick(); ext_req = 1'b1;
    tick(); ext_req = 1'b0;
  endtask

  // Driver loop: resumes pauses, answers fetches, injects failures, stops at done.
  task automatic run_xfer(input int fail_at, input bit use_err,
                          output int resumes, output int fetches,
                          output bit finished, output bit fetch_cs_ok);
    int  idx = 0;
    bit  phase = 0, fd_prev = 0, fired = 0;
    resumes = 0; fetches = 0; finished = 0; fetch_cs_ok = 1;
    for (int c = 0; c < 2000; c++) begin
      tick();
      if (ext_done) begin finished = 1; break; end
      ext_req = 1'b0; fetch_done = 1'b0; xfer_err = 1'b0;
      beat_ready = bp ? (c % 3 != 2) : 1'b1;
      if (fetch_req && !start_bit) fetch_cs_ok = 0;
      if (busy_stat && !start_bit) begin ext_req = 1'b1; resumes++; end
      if (fetch_req && !fd_prev) begin
        fetch_done  = 1'b1;
        fetch_beats = 16'(seg_b[idx]);
        fetch_last  = (idx == seg_n - 1);
        fetches++;
        if (!ext_mode || phase) begin idx++; phase = 0; end
        else phase = 1;
      end
      fd_prev = fetch_done;
      if (fail_at >= 0 && mon_beats >= fail_at && !fired) begin
        fired = 1;
        if (use_err) xfer_err = 1'b1; else abort_req = 1'b1;
      end
    end
    ext_req = 1'b0; fetch_done = 1'b0; xfer_err = 1'b0; beat_ready = 1'b1;
    if (finished) begin
      chk("R4 busy low at done", int'(busy_stat), 0);
      chk("R4 ack low at done", int'(ext_ack), 0);
      chk("R4 start low at done", int'(start_bit), 0);
      tick();
      chk("R4 done single cycle", int'(ext_done), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int  res, fet;
    bit  fin, fok;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 ack", int'(ext_ack), 0);
    chk("R1 busy", int'(busy_stat), 0);
    chk("R1 start", int'(start_bit), 0);
    chk("R1 done", int'(ext_done), 0);
    chk("R1 err", int'(err_stat), 0);
    chk("R1 valid/fetch", int'(beat_valid | fetch_req), 0);

    // R2: request edge ignored while external control disabled
    xfer_beats = 16'd4;
    pulse_ext(); tick();
    chk("R2 disabled req ignored", int'(busy_stat), 0);
    ext_ctl_en = 1'b1;

    // R7: descriptor load ignored in direct mode
    tick(); desc_load = 1'b1; tick(); desc_load = 1'b0; tick();
    chk("R7 desc_load ignored direct", int'(busy_stat), 0);

    // R2/R3: start by edge, hold the request, then drop it
    xfer_beats = 16'd5;
    sbq.push_back('{beats: 5, err: 1'b0});
    tick(); ext_req = 1'b1;
    tick();
    chk("R2 busy after edge", int'(busy_stat), 1);
    chk("R2 ack after edge", int'(ext_ack), 1);
    chk("R2 start after edge", int'(start_bit), 1);
    tick(); ext_req = 1'b0;
    tick();
    chk("R2 drop keeps start", int'(start_bit), 1);
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R3 direct finished", int'(fin), 1);

    // R3: zero-length direct transfer via software start
    xfer_beats = 16'd0;
    sbq.push_back('{beats: 0, err: 1'b0});
    tick(); sw_start = 1'b1; tick(); sw_start = 1'b0;
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R3 zero length finished", int'(fin), 1);

    // R3: back-pressure
    xfer_beats = 16'd6; bp = 1;
    sbq.push_back('{beats: 6, err: 1'b0});
    tick(); sw_start = 1'b1; tick(); sw_start = 1'b0;
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R3 backpressure finished", int'(fin), 1);
    bp = 0;

    // R5/R6: quota 16 bytes, 5 beats -> pauses after beats 2 and 4
    pause_en = 1'b1; quota_exp = 4'd4; xfer_beats = 16'd5;
    sbq.push_back('{beats: 5, err: 1'b0});
    pulse_ext();
    repeat (4) tick();
    chk("R5 paused start low", int'(start_bit), 0);
    chk("R5 paused busy high", int'(busy_stat), 1);
    chk("R5 paused valid low", int'(beat_valid), 0);
    chk("R5 beats before pause", mon_beats, 2);
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R6 resumes for 5 beats", res, 2);

    // R5: quota reached on final beat -> no pause there
    xfer_beats = 16'd4;
    sbq.push_back('{beats: 4, err: 1'b0});
    pulse_ext();
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R5 final beat no pause", res, 1);
    pause_en = 1'b0;

    // R7: basic chaining, two segments, back-pressure
    xfer_mode = 2'b01; seg_b[0] = 3; seg_b[1] = 2; seg_n = 2; ext_mode = 0; bp = 1;
    sbq.push_back('{beats: 5, err: 1'b0});
    tick(); desc_load = 1'b1; tick(); desc_load = 1'b0;
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R7 chain fetches", fet, 2);
    bp = 0;

    // R8: extended chaining, two descriptors, two fetches each
    xfer_mode = 2'b11; seg_b[0] = 1; seg_b[1] = 1; seg_n = 2; ext_mode = 1;
    sbq.push_back('{beats: 2, err: 1'b0});
    pulse_ext();
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R8 extended fetches", fet, 4);
    ext_mode = 0;

    // R9: chaining with 8-byte quota; pause deferred past the fetch
    xfer_mode = 2'b01; pause_en = 1'b1; quota_exp = 4'd3;
    seg_b[0] = 1; seg_b[1] = 2; seg_n = 2;
    sbq.push_back('{beats: 3, err: 1'b0});
    pulse_ext();
    run_xfer(-1, 0, res, fet, fin, fok);
    chk("R9 start held during fetch", int'(fok), 1);
    chk("R9 resumes", res, 2);
    pause_en = 1'b0;

    // R10: abort edge mid-transfer, then R12 clear
    xfer_mode = 2'b00; xfer_beats = 16'd10;
    sbq.push_back('{beats: -1, err: 1'b1});
    pulse_ext();
    run_xfer(3, 0, res, fet, fin, fok);
    chk("R10 abort ends transfer", int'(fin), 1);
    abort_req = 1'b0;
    chk("R12 err sticky", int'(err_stat), 1);
    tick(); err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R12 err cleared", int'(err_stat), 0);

    // R11: transfer error in chaining mode
    xfer_mode = 2'b01; seg_b[0] = 5; seg_n = 1;
    sbq.push_back('{beats: -1, err: 1'b1});
    pulse_ext();
    run_xfer(2, 1, res, fet, fin, fok);
    chk("R11 error ends transfer", int'(fin), 1);
    tick(); err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R12 err cleared again", int'(err_stat), 0);

    repeat (3) tick();
    chk("R4 scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule